// File: doc/BRIEF.md
# Multiplexed CPU Bus Bridge

The bridge sits between a processor with a 32-bit bus that carries both address and data on the same pins, and an on-chip bus that keeps address, write data, read data, strobes and acknowledge on separate wires. The processor marks each transaction with an address strobe and holds a cycle-in-progress line low until its last beat is acknowledged. The bridge captures the upper address at the strobe and passes the two word-select lines through as they change. It then runs one internal request per data beat and returns a one-clock acknowledge for each beat, with read data driven onto the shared pins during that clock.

Accesses that land in one address window never reach the internal bus. They are sent to an external byte-wide peripheral, using its own chip select, read strobe and write strobe for a fixed number of clocks.

A reset sequencer keeps the processor in cold reset, and then in warm reset, for set clock counts. While cold reset is held, it drives five mode bits onto the bus-grant and interrupt pins. Once the processor is released, the same pins carry the two device interrupts.

Top module: `cpu_bus_bridge`

## Requirements
- R1: `ib_addr_o[29:2]` equals `cpu_ad_i[31:4]` as sampled on the clock edge where `cpu_ale_i` is high. `ib_addr_o[1:0]` follows the live `cpu_wsel_i` lines during every beat.
- R2: During an internal write beat, `ib_wr_o[i]` is high exactly when `cpu_be_n_i[i]` is low, `ib_rd_o` is low, and `ib_wdata_o` equals `cpu_ad_i`. During a read beat, `ib_rd_o` is high and `ib_wr_o` is 0.
- R3: `ib_req_o` stays high until the clock in which `ib_ack_i` is high. It is low in the following clock.
- R4: `cpu_ack_n_o` is low for exactly one clock per beat, in the clock after the target's acknowledge (for the peripheral, after its strobe ends). On a read, `cpu_ad_oe_o` is high in that clock and `cpu_ad_o` carries the returned data. On a write, `cpu_ad_oe_o` stays low.
- R5: While `cpu_cip_n_i` stays low, each new read or write strobe after an acknowledge starts another beat. Once `cpu_cip_n_i` is high, no further request or acknowledge occurs until the next address strobe.
- R6: The peripheral window is the set of addresses whose bits [31:WIN_LSB] match WIN_BASE. An access in the window raises no internal request. Instead, `per_cs_n_o` is low for PER_CYC clocks, together with `per_rd_n_o` (read) or `per_wr_n_o` (write). `per_addr_o` is the low PER_AW bits of the word address, and `per_dout_o` is `cpu_ad_i[7:0]`. Read data returns as `{24'b0, per_din_i}`.
- R7: After `rst_n` is released, `cpu_cold_rst_n_o` rises on the COLD_CYC-th clock edge, and `cpu_warm_rst_n_o` rises WARM_CYC edges after that. Warm reset is low whenever cold reset is low.
- R8: While cold reset is low, `cpu_busgnt_n_o` equals MODE_BITS[0] and `cpu_int_n_o` equals MODE_BITS[4:1]. In the warm-only phase, both pins are driven all high.
- R9: Once warm reset is high, `cpu_busgnt_n_o` is high. `cpu_int_n_o` is `{1,1,~irq_audio_i,~irq_ir_i}`, registered with one clock of delay.
- R10: While `rst_n` is low, `cpu_ack_n_o` and `per_cs_n_o` are high, `ib_req_o` and `cpu_ad_oe_o` are low, and both processor resets are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ad_i | input | 32 | Shared address/data pins, inbound |
| cpu_ad_o | output | 32 | Read data onto the shared pins |
| cpu_ad_oe_o | output | 1 | Drive enable for `cpu_ad_o` |
| cpu_ale_i | input | 1 | Address strobe |
| cpu_wsel_i | input | 2 | Word-select lines (address bits 3:2) |
| cpu_be_n_i | input | 4 | Byte-lane enables, active low |
| cpu_cip_n_i | input | 1 | Cycle in progress, active low |
| cpu_rd_n_i | input | 1 | Read strobe, active low |
| cpu_wr_n_i | input | 1 | Write strobe, active low |
| cpu_ack_n_o | output | 1 | Beat acknowledge, active low |
| ib_req_o | output | 1 | Internal bus request |
| ib_addr_o | output | 30 | Internal word address (byte address bits 31:2) |
| ib_rd_o | output | 1 | Internal read |
| ib_wr_o | output | 4 | Internal byte write strobes |
| ib_wdata_o | output | 32 | Internal write data |
| ib_rdata_i | input | 32 | Internal read data |
| ib_ack_i | input | 1 | Internal target acknowledge |
| per_cs_n_o | output | 1 | Peripheral chip select, active low |
| per_rd_n_o | output | 1 | Peripheral read strobe, active low |
| per_wr_n_o | output | 1 | Peripheral write strobe, active low |
| per_addr_o | output | PER_AW | Peripheral register address |
| per_dout_o | output | 8 | Peripheral write data |
| per_din_i | input | 8 | Peripheral read data |
| irq_ir_i | input | 1 | Infrared interrupt source |
| irq_audio_i | input | 1 | Audio interrupt source |
| cpu_cold_rst_n_o | output | 1 | Processor cold (power-on) reset |
| cpu_warm_rst_n_o | output | 1 | Processor warm reset |
| cpu_busgnt_n_o | output | 1 | Bus grant pin / mode bit 0 |
| cpu_int_n_o | output | 4 | Interrupt pins / mode bits 4:1 |

## Verification
The beat path is exercised in several ways:
- Single writes and reads show that address capture and the data return path work.
- A four-beat burst that starts at word select 2 and wraps shows that the low address bits come from the live lines rather than from a counter.
- A write with a sparse byte-enable mask, followed by a read-back, separates lane mapping from whole-word writes.
- Target latencies of zero and three clocks separate a request that is held correctly from one that is dropped early.
- Reads and writes inside the peripheral window show that the traffic is diverted and that strobe width is kept.
- Toggling the two interrupt sources after release shows the pin mapping and its one-clock delay.

// File: rtl/cbb_pkg.sv
// Shared types and widths for the multiplexed CPU bus bridge.
// Assumes a 32-bit processor bus with word-select lines for bits [3:2].
package cbb_pkg;
    localparam int DATA_W = 32;
    localparam int WORD_AW = 30;
    localparam int BE_W = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_BEAT,
        ST_PER,
        ST_ACK
    } bus_st_t;

    typedef enum logic [1:0] {
        PH_COLD,
        PH_WARM,
        PH_RUN
    } rst_ph_t;
endpackage

// File: rtl/cbb_addr_latch.sv
// Address capture: stores the upper address bits from the shared pins
// on the address strobe and flags whether they fall in the peripheral
// window. The word-select bits are taken live from their own lines.
// Assumes WIN_LSB >= 4 so the window compare only uses latched bits.
module cbb_addr_latch
    import cbb_pkg::*;
#(
    parameter int          WIN_LSB  = 12,
    parameter logic [31:0] WIN_BASE = 32'h1F00_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ale,
    input  logic [31:4]        ad_hi,
    input  logic [1:0]         wsel,
    output logic [WORD_AW-1:0] word_addr,
    output logic               win_hit
);
    logic [31:4] hi_q;

    // Capture upper address and window decode at the address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            win_hit <= 1'b0;
        end else if (ale) begin
            hi_q    <= ad_hi;
            win_hit <= (ad_hi[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
        end
    end

    // Join the stored upper part with the live word-select lines.
    always_comb word_addr = {hi_q, wsel};
endmodule

// File: rtl/cbb_beat_ctrl.sv
// Beat sequencer: turns processor strobes into one internal request or
// one peripheral strobe window per beat, and returns a single-clock
// acknowledge with captured read data. A decide clock after each
// acknowledge lets the processor update its strobes before the next beat.
module cbb_beat_ctrl
    import cbb_pkg::*;
#(
    parameter int PER_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              cip_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BE_W-1:0]   be_n,
    input  logic              win_hit,
    input  logic              ib_ack,
    input  logic [DATA_W-1:0] ib_rdata,
    input  logic [7:0]        per_din,
    output logic              ib_req,
    output logic              ib_rd,
    output logic [BE_W-1:0]   ib_wr,
    output logic              ack_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              per_cs_n,
    output logic              per_rd_n,
    output logic              per_wr_n
);
    localparam int PCW = $clog2(PER_CYC + 1);
    localparam logic [PCW-1:0] PER_LAST = PCW'(PER_CYC - 1);

    bus_st_t           st;
    logic              is_wr;
    logic [PCW-1:0]    pcnt;
    logic [DATA_W-1:0] rdata_q;

    // Beat state machine with direction, strobe counter and read data hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            is_wr   <= 1'b0;
            pcnt    <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (ale) st <= ST_DECIDE;
                ST_DECIDE: begin
                    if (cip_n) begin
                        st <= ST_IDLE;
                    end else if (!rd_n || !wr_n) begin
                        is_wr <= !wr_n;
                        pcnt  <= '0;
                        st    <= win_hit ? ST_PER : ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    if (ib_ack) begin
                        rdata_q <= ib_rdata;
                        st      <= ST_ACK;
                    end
                end
                ST_PER: begin
                    pcnt <= pcnt + 1'b1;
                    if (pcnt == PER_LAST) begin
                        rdata_q <= {{(DATA_W-8){1'b0}}, per_din};
                        st      <= ST_ACK;
                    end
                end
                ST_ACK:  st <= ST_DECIDE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode strobes and acknowledge from the beat state.
    always_comb begin
        ib_req   = (st == ST_BEAT);
        ib_rd    = (st == ST_BEAT) && !is_wr;
        ib_wr    = ((st == ST_BEAT) && is_wr) ? ~be_n : '0;
        ack_n    = (st != ST_ACK);
        ad_oe    = (st == ST_ACK) && !is_wr;
        ad_out   = rdata_q;
        per_cs_n = (st != ST_PER);
        per_rd_n = !((st == ST_PER) && !is_wr);
        per_wr_n = !((st == ST_PER) && is_wr);
    end
endmodule

// File: rtl/cbb_reset_seq.sv
// Processor reset sequencer: holds cold reset, then warm reset, for set
// clock counts. Mode bits go onto the grant and interrupt pins during cold
// reset; after release the pins carry registered device interrupts.
// Assumes COLD_CYC and WARM_CYC are at least 1.
module cbb_reset_seq
    import cbb_pkg::*;
#(
    parameter int         COLD_CYC  = 64,
    parameter int         WARM_CYC  = 32,
    parameter logic [4:0] MODE_BITS = 5'b00001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_ir,
    input  logic       irq_audio,
    output logic       cold_n,
    output logic       warm_n,
    output logic       busgnt_n,
    output logic [3:0] int_n
);
    localparam int MAXC = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] COLD_LAST = CW'(COLD_CYC - 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(WARM_CYC - 1);

    rst_ph_t       ph;
    logic [CW-1:0] cnt;
    logic [3:0]    int_q;

    // Phase counter: cold for COLD_CYC clocks, then warm for WARM_CYC clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_COLD;
            cnt <= '0;
        end else begin
            case (ph)
                PH_COLD: begin
                    if (cnt == COLD_LAST) begin
                        ph  <= PH_WARM;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WARM: begin
                    if (cnt == WARM_LAST) begin
                        ph  <= PH_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_RUN;
            endcase
        end
    end

    // Register the interrupt sources into active-low pin form.
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= 4'hF;
        else        int_q <= ~{2'b00, irq_audio, irq_ir};
    end

    // Select pin contents by phase.
    always_comb begin
        cold_n   = (ph != PH_COLD);
        warm_n   = (ph == PH_RUN);
        busgnt_n = 1'b1;
        int_n    = 4'hF;
        if (ph == PH_COLD) begin
            busgnt_n = MODE_BITS[0];
            int_n    = MODE_BITS[4:1];
        end else if (ph == PH_RUN) begin
            int_n = int_q;
        end
    end
endmodule

// File: rtl/cpu_bus_bridge.sv
// Top of the multiplexed CPU bus bridge: address capture, beat sequencer
// with peripheral diversion, and processor reset/mode sequencer.
// Assumes one clock shared with the processor bus; the shared pins are
// split into inbound data, outbound data and a drive enable.
module cpu_bus_bridge
    import cbb_pkg::*;
#(
    parameter int          PER_AW    = 4,
    parameter int          PER_CYC   = 3,
    parameter int          WIN_LSB   = 12,
    parameter logic [31:0] WIN_BASE  = 32'h1F00_0000,
    parameter int          COLD_CYC  = 64,
    parameter int          WARM_CYC  = 32,
    parameter logic [4:0]  MODE_BITS = 5'b00001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  cpu_ad_i,
    output logic [DATA_W-1:0]  cpu_ad_o,
    output logic               cpu_ad_oe_o,
    input  logic               cpu_ale_i,
    input  logic [1:0]         cpu_wsel_i,
    input  logic [BE_W-1:0]    cpu_be_n_i,
    input  logic               cpu_cip_n_i,
    input  logic               cpu_rd_n_i,
    input  logic               cpu_wr_n_i,
    output logic               cpu_ack_n_o,
    output logic               ib_req_o,
    output logic [WORD_AW-1:0] ib_addr_o,
    output logic               ib_rd_o,
    output logic [BE_W-1:0]    ib_wr_o,
    output logic [DATA_W-1:0]  ib_wdata_o,
    input  logic [DATA_W-1:0]  ib_rdata_i,
    input  logic               ib_ack_i,
    output logic               per_cs_n_o,
    output logic               per_rd_n_o,
    output logic               per_wr_n_o,
    output logic [PER_AW-1:0]  per_addr_o,
    output logic [7:0]         per_dout_o,
    input  logic [7:0]         per_din_i,
    input  logic               irq_ir_i,
    input  logic               irq_audio_i,
    output logic               cpu_cold_rst_n_o,
    output logic               cpu_warm_rst_n_o,
    output logic               cpu_busgnt_n_o,
    output logic [3:0]         cpu_int_n_o
);
    logic [WORD_AW-1:0] word_addr;
    logic               win_hit;

    cbb_addr_latch #(
        .WIN_LSB  (WIN_LSB),
        .WIN_BASE (WIN_BASE)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (cpu_ale_i),
        .ad_hi     (cpu_ad_i[31:4]),
        .wsel      (cpu_wsel_i),
        .word_addr (word_addr),
        .win_hit   (win_hit)
    );

    cbb_beat_ctrl #(
        .PER_CYC (PER_CYC)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (cpu_ale_i),
        .cip_n    (cpu_cip_n_i),
        .rd_n     (cpu_rd_n_i),
        .wr_n     (cpu_wr_n_i),
        .be_n     (cpu_be_n_i),
        .win_hit  (win_hit),
        .ib_ack   (ib_ack_i),
        .ib_rdata (ib_rdata_i),
        .per_din  (per_din_i),
        .ib_req   (ib_req_o),
        .ib_rd    (ib_rd_o),
        .ib_wr    (ib_wr_o),
        .ack_n    (cpu_ack_n_o),
        .ad_out   (cpu_ad_o),
        .ad_oe    (cpu_ad_oe_o),
        .per_cs_n (per_cs_n_o),
        .per_rd_n (per_rd_n_o),
        .per_wr_n (per_wr_n_o)
    );

    cbb_reset_seq #(
        .COLD_CYC  (COLD_CYC),
        .WARM_CYC  (WARM_CYC),
        .MODE_BITS (MODE_BITS)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_ir    (irq_ir_i),
        .irq_audio (irq_audio_i),
        .cold_n    (cpu_cold_rst_n_o),
        .warm_n    (cpu_warm_rst_n_o),
        .busgnt_n  (cpu_busgnt_n_o),
        .int_n     (cpu_int_n_o)
    );

    // Route address and write data straight from the capture and the pins.
    always_comb begin
        ib_addr_o  = word_addr;
        ib_wdata_o = cpu_ad_i;
        per_addr_o = word_addr[PER_AW-1:0];
        per_dout_o = cpu_ad_i[7:0];
    end
endmodule

// File: rtl/cpu_bus_bridge_chk.sv
// Protocol checker for the bridge, bound to every instance of the top.
module cpu_bus_bridge_chk #(
    parameter logic [4:0] MODE_BITS = 5'b00001
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ack_n_o,
    input logic       ib_req_o,
    input logic       ib_ack_i,
    input logic       per_cs_n_o,
    input logic       irq_ir_i,
    input logic       irq_audio_i,
    input logic       cpu_cold_rst_n_o,
    input logic       cpu_warm_rst_n_o,
    input logic       cpu_busgnt_n_o,
    input logic [3:0] cpu_int_n_o
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req_o && !ib_ack_i |=> ib_req_o);

    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req_o && ib_ack_i |=> !ib_req_o);

    p_ack_after_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req_o && ib_ack_i |=> !cpu_ack_n_o);

    p_ack_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack_n_o |=> cpu_ack_n_o);

    p_no_req_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !per_cs_n_o |-> !ib_req_o);

    p_warm_covers_cold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_cold_rst_n_o |-> !cpu_warm_rst_n_o);

    p_mode_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_cold_rst_n_o |-> (cpu_busgnt_n_o == MODE_BITS[0]) && (cpu_int_n_o == MODE_BITS[4:1]));

    p_irq_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_warm_rst_n_o |-> cpu_int_n_o == ~{2'b00, $past(irq_audio_i), $past(irq_ir_i)});
endmodule

bind cpu_bus_bridge cpu_bus_bridge_chk #(.MODE_BITS(MODE_BITS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cpu_ack_n_o      (cpu_ack_n_o),
    .ib_req_o         (ib_req_o),
    .ib_ack_i         (ib_ack_i),
    .per_cs_n_o       (per_cs_n_o),
    .irq_ir_i         (irq_ir_i),
    .irq_audio_i      (irq_audio_i),
    .cpu_cold_rst_n_o (cpu_cold_rst_n_o),
    .cpu_warm_rst_n_o (cpu_warm_rst_n_o),
    .cpu_busgnt_n_o   (cpu_busgnt_n_o),
    .cpu_int_n_o      (cpu_int_n_o)
);

// File: tb/cpu_bus_bridge_bench.sv
// Scoreboard bench: the processor driver task queues expected internal
// beats, peripheral strobes and read data; negedge monitors pop and compare.
module cpu_bus_bridge_bench;
    localparam int          PER_AW    = 4;
    localparam int          PER_CYC   = 3;
    localparam int          WIN_LSB   = 12;
    localparam logic [31:0] WIN_BASE  = 32'h1F00_0000;
    localparam int          COLD_CYC  = 12;
    localparam int          WARM_CYC  = 6;
    localparam logic [4:0]  MODE_BITS = 5'b10110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] cpu_ad_i = '0;
    logic [31:0] cpu_ad_o;
    logic cpu_ad_oe_o;
    logic cpu_ale_i = 1'b0;
    logic [1:0] cpu_wsel_i = '0;
    logic [3:0] cpu_be_n_i = 4'hF;
    logic cpu_cip_n_i = 1'b1;
    logic cpu_rd_n_i = 1'b1;
    logic cpu_wr_n_i = 1'b1;
    logic cpu_ack_n_o;
    logic ib_req_o;
    logic [29:0] ib_addr_o;
    logic ib_rd_o;
    logic [3:0] ib_wr_o;
    logic [31:0] ib_wdata_o;
    logic [31:0] ib_rdata_i = '0;
    logic ib_ack_i = 1'b0;
    logic per_cs_n_o, per_rd_n_o, per_wr_n_o;
    logic [PER_AW-1:0] per_addr_o;
    logic [7:0] per_dout_o;
    logic [7:0] per_din_i;
    logic irq_ir_i = 1'b0;
    logic irq_audio_i = 1'b0;
    logic cpu_cold_rst_n_o, cpu_warm_rst_n_o, cpu_busgnt_n_o;
    logic [3:0] cpu_int_n_o;

    always #4 clk = ~clk;

    cpu_bus_bridge #(
        .PER_AW(PER_AW), .PER_CYC(PER_CYC), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE),
        .COLD_CYC(COLD_CYC), .WARM_CYC(WARM_CYC), .MODE_BITS(MODE_BITS)
    ) u_cpu_bus_bridge (.*);

    typedef struct packed {
        logic [29:0] addr;
        logic        rd;
        logic [3:0]  wr;
        logic [31:0] wdata;
    } ib_item_t;

    typedef struct packed {
        logic [3:0] addr;
        logic       wr;
        logic [7:0] d;
    } per_item_t;

    ib_item_t    exp_ib[$];
    per_item_t   exp_per[$];
    logic [31:0] exp_rd[$];
    logic [31:0] ref_mem [16];
    logic [31:0] mem [16];

    int n_checks = 0;
    int n_err = 0;
    int lat = 0;
    int wait_cnt = 0;
    int acks_seen = 0;
    int beats_issued = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Peripheral returns a value derived from its register address.
    assign per_din_i = {4'hA, per_addr_o};

    // Internal target model: acknowledge after lat waiting clocks.
    always @(posedge clk) begin
        if (!rst_n) begin
            ib_ack_i <= 1'b0;
            wait_cnt <= 0;
        end else if (ib_ack_i) begin
            ib_ack_i <= 1'b0;
            for (int i = 0; i < 4; i++)
                if (ib_wr_o[i]) mem[ib_addr_o[3:0]][8*i +: 8] <= ib_wdata_o[8*i +: 8];
        end else if (ib_req_o) begin
            if (wait_cnt >= lat) begin
                ib_ack_i   <= 1'b1;
                ib_rdata_i <= mem[ib_addr_o[3:0]];
                wait_cnt   <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // Monitor: internal beat contents in the acceptance clock (R1, R2).
    always @(negedge clk) begin
        if (rst_n && ib_req_o && ib_ack_i) begin
            if (exp_ib.size() == 0) begin
                chk(1'b0, "R5", "unexpected internal request", {2'b0, ib_addr_o}, 32'h0);
            end else begin
                ib_item_t e;
                e = exp_ib.pop_front();
                chk(ib_addr_o == e.addr, "R1", "word address", {2'b0, ib_addr_o}, {2'b0, e.addr});
                chk(ib_rd_o == e.rd && ib_wr_o == e.wr, "R2", "rd/byte strobes",
                    {27'b0, ib_rd_o, ib_wr_o}, {27'b0, e.rd, e.wr});
                if (!e.rd) chk(ib_wdata_o == e.wdata, "R2", "write data", ib_wdata_o, e.wdata);
            end
        end
    end

    // Monitor: processor acknowledge and read return (R4).
    logic prev_ack_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !cpu_ack_n_o) begin
            acks_seen++;
            chk(prev_ack_n, "R4", "acknowledge longer than one clock", 32'h0, 32'h1);
            if (cpu_ad_oe_o) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R4", "unexpected read data", cpu_ad_o, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    chk(cpu_ad_o == e, "R4", "read data", cpu_ad_o, e);
                end
            end
        end
        prev_ack_n = cpu_ack_n_o;
    end

    // Monitor: peripheral strobes, contents and width (R6).
    logic prev_cs_n = 1'b1;
    int   cs_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!per_cs_n_o) begin
                if (prev_cs_n) begin
                    cs_len = 0;
                    if (exp_per.size() == 0) begin
                        chk(1'b0, "R6", "unexpected peripheral access", {28'b0, per_addr_o}, 32'h0);
                    end else begin
                        per_item_t e;
                        e = exp_per.pop_front();
                        chk(per_addr_o == e.addr, "R6", "peripheral address", {28'b0, per_addr_o}, {28'b0, e.addr});
                        chk(per_wr_n_o == !e.wr && per_rd_n_o == e.wr, "R6", "peripheral strobe select",
                            {30'b0, per_rd_n_o, per_wr_n_o}, {30'b0, e.wr, !e.wr});
                        if (e.wr) chk(per_dout_o == e.d, "R6", "peripheral write data", {24'b0, per_dout_o}, {24'b0, e.d});
                    end
                end
                chk(!ib_req_o, "R6", "internal request during window access", {31'b0, ib_req_o}, 32'h0);
                cs_len++;
            end else if (!prev_cs_n) begin
                chk(cs_len == PER_CYC, "R6", "chip select width", cs_len, PER_CYC);
            end
        end
        prev_cs_n = per_cs_n_o;
    end

    // Processor model: one transaction of n beats with wrapping word select.
    task automatic cpu_burst(input logic [31:0] addr, input bit wr, input int n, input logic [3:0] be);
        bit hit;
        hit = (addr[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
        @(posedge clk); #1;
        cpu_ale_i = 1'b1; cpu_ad_i = addr; cpu_cip_n_i = 1'b0; cpu_wsel_i = addr[3:2];
        @(posedge clk); #1;
        cpu_ale_i = 1'b0;
        for (int b = 0; b < n; b++) begin
            logic [1:0]  ws;
            logic [29:0] wa;
            logic [31:0] d;
            ws = addr[3:2] + b[1:0];
            wa = {addr[31:4], ws};
            d  = 32'hC0DE_0000 ^ {wa[15:0], 16'h5A00 + 16'(b)};
            cpu_wsel_i = ws;
            cpu_be_n_i = ~be;
            if (wr) begin cpu_ad_i = d; cpu_wr_n_i = 1'b0; cpu_rd_n_i = 1'b1; end
            else    begin cpu_ad_i = 32'hDEAD_BEEF; cpu_rd_n_i = 1'b0; cpu_wr_n_i = 1'b1; end
            if (hit) begin
                exp_per.push_back('{addr: wa[3:0], wr: wr, d: d[7:0]});
                if (!wr) exp_rd.push_back({24'b0, 4'hA, wa[3:0]});
            end else begin
                exp_ib.push_back('{addr: wa, rd: !wr, wr: wr ? be : 4'h0, wdata: d});
                if (wr) begin
                    for (int i = 0; i < 4; i++)
                        if (be[i]) ref_mem[wa[3:0]][8*i +: 8] = d[8*i +: 8];
                end else begin
                    exp_rd.push_back(ref_mem[wa[3:0]]);
                end
            end
            beats_issued++;
            do @(negedge clk); while (cpu_ack_n_o !== 1'b0);
            @(posedge clk); #1;
        end
        cpu_cip_n_i = 1'b1; cpu_rd_n_i = 1'b1; cpu_wr_n_i = 1'b1; cpu_ad_i = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        int edges;
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'h1000_0000 + i;
            ref_mem[i] = 32'h1000_0000 + i;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(cpu_ack_n_o && per_cs_n_o && !ib_req_o && !cpu_ad_oe_o, "R10", "bus idle in reset",
            {28'b0, cpu_ack_n_o, per_cs_n_o, ib_req_o, cpu_ad_oe_o}, 32'hC);
        chk(!cpu_cold_rst_n_o && !cpu_warm_rst_n_o, "R10", "resets held",
            {30'b0, cpu_cold_rst_n_o, cpu_warm_rst_n_o}, 32'h0);
        // R8: mode bits on grant and interrupt pins
        chk({cpu_int_n_o, cpu_busgnt_n_o} == MODE_BITS, "R8", "mode pins in cold reset",
            {27'b0, cpu_int_n_o, cpu_busgnt_n_o}, {27'b0, MODE_BITS});

        @(posedge clk); #1; rst_n = 1'b1;
        edges = 0;
        do begin
            @(posedge clk); edges++; @(negedge clk);
            if (!cpu_cold_rst_n_o)
                chk(!cpu_warm_rst_n_o && {cpu_int_n_o, cpu_busgnt_n_o} == MODE_BITS, "R8",
                    "mode pins / warm held", {26'b0, cpu_warm_rst_n_o, cpu_int_n_o, cpu_busgnt_n_o}, {27'b0, MODE_BITS});
        end while (!cpu_cold_rst_n_o && edges < 100);
        chk(edges == COLD_CYC, "R7", "cold reset length", edges, COLD_CYC);
        chk(cpu_busgnt_n_o && cpu_int_n_o == 4'hF, "R8", "pins idle in warm phase",
            {27'b0, cpu_int_n_o, cpu_busgnt_n_o}, 32'h1F);
        edges = 0;
        do begin
            @(posedge clk); edges++; @(negedge clk);
        end while (!cpu_warm_rst_n_o && edges < 100);
        chk(edges == WARM_CYC, "R7", "warm reset length", edges, WARM_CYC);

        // R9: interrupt sources onto pins with one clock delay
        chk(cpu_busgnt_n_o && cpu_int_n_o == 4'hF, "R9", "pins quiet after release",
            {27'b0, cpu_int_n_o, cpu_busgnt_n_o}, 32'h1F);
        @(posedge clk); #1; irq_ir_i = 1'b1;
        @(negedge clk);
        chk(cpu_int_n_o == 4'hF, "R9", "no change before register", {28'b0, cpu_int_n_o}, 32'hF);
        @(negedge clk);
        chk(cpu_int_n_o == 4'hE, "R9", "ir source on pin 0", {28'b0, cpu_int_n_o}, 32'hE);
        @(posedge clk); #1; irq_ir_i = 1'b0; irq_audio_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(cpu_int_n_o == 4'hD, "R9", "audio source on pin 1", {28'b0, cpu_int_n_o}, 32'hD);
        @(posedge clk); #1; irq_ir_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(cpu_int_n_o == 4'hC, "R9", "both sources", {28'b0, cpu_int_n_o}, 32'hC);
        chk(cpu_busgnt_n_o, "R9", "grant pin released", {31'b0, cpu_busgnt_n_o}, 32'h1);

        // R1, R2, R4: single beats, zero latency
        lat = 0;
        cpu_burst(32'h0000_0104, 1'b1, 1, 4'hF);
        cpu_burst(32'h0000_0104, 1'b0, 1, 4'hF);
        // R5, R1: wrapping burst starting at word select 2, with latency
        lat = 3;
        cpu_burst(32'h0000_0228, 1'b1, 4, 4'hF);
        cpu_burst(32'h0000_0228, 1'b0, 4, 4'hF);
        // R2: sparse byte lanes then read back
        lat = 1;
        cpu_burst(32'h0000_0230, 1'b1, 1, 4'b0101);
        cpu_burst(32'h0000_0230, 1'b0, 1, 4'hF);
        // R6: peripheral window accesses
        cpu_burst(32'h1F00_0014, 1'b1, 2, 4'hF);
        cpu_burst(32'h1F00_0018, 1'b0, 3, 4'hF);
        // Back to the internal bus after the window
        lat = 2;
        cpu_burst(32'h0000_0300, 1'b0, 2, 4'hF);

        // R5: quiet after cycle-in-progress rises, all beats served
        repeat (6) begin
            @(negedge clk);
            chk(cpu_ack_n_o && !ib_req_o && per_cs_n_o, "R5", "idle after transaction",
                {29'b0, cpu_ack_n_o, ib_req_o, per_cs_n_o}, 32'h5);
        end
        chk(acks_seen == beats_issued, "R5", "one acknowledge per beat", acks_seen, beats_issued);
        chk(exp_ib.size() == 0 && exp_per.size() == 0 && exp_rd.size() == 0, "R5",
            "scoreboard drained", exp_ib.size() + exp_per.size() + exp_rd.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule